// File: doc/BRIEF.md
# Vector element insert unit

This block executes a family of eight instructions that drop a scalar into one element slot of a 128-bit vector register. Each request carries a 32-bit instruction word, a 64-bit scalar, a 64-bit register holding a byte index, and the current contents of the target vector. The instruction picks an element width of one, two, four or eight bytes. It also picks whether the index counts from the leftmost byte or from the rightmost byte. The unit writes the low bytes of the scalar into the chosen slot and keeps every other byte as it was.

The result is registered one clock after the request and comes with a done strobe. If the slot would run past either end of the vector, no write happens: the output carries the incoming vector unmodified, and a range-error flag pulses. If the word is not one of the eight encodings, an illegal-instruction flag pulses and the output register keeps its previous value. Register reads, exception delivery and hazard handling belong to the surrounding pipeline.

Top module: `vec_insert_unit`

## Requirements
- R1: An instruction is recognised only when instr[31:26] is 6'b000100, instr[10:9] is 2'b01 and instr[5:0] is 6'b001111. Within it, instr[8] set selects right-counting, and instr[7:6] selects the element width: 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes, 3 for 8 bytes.
- R2: The inserted element is the least significant width×8 bits of src_val.
- R3: Only idx_reg[3:0] affects the result; the raw index is 0 to 15.
- R4: With left-counting, the element starts at byte position equal to the raw index. Byte 0 is vec bits 127:120, and byte k is bits 127-8k down to 120-8k.
- R5: With right-counting, the start position is 16 − width − raw index.
- R6: The element fills bytes pos through pos+width−1, with its most significant byte at byte pos. All other bytes equal vec_in.
- R7: When the raw index exceeds 16 − width, the output is vec_in unchanged and range_err is high for one cycle.
- R8: An unrecognised instruction raises illegal for one cycle. vec_out keeps its previous value, and range_err stays low.
- R9: Results appear on the clock edge after req_valid, with done high for exactly that cycle. Without a request, done and both flags are low and vec_out holds.
- R10: Synchronous active-high reset clears vec_out, done, range_err and illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| instr | input | 32 | Instruction word |
| src_val | input | 64 | Scalar to insert |
| idx_reg | input | 64 | Register holding the byte index |
| vec_in | input | 128 | Current target vector |
| vec_out | output | 128 | Registered result vector |
| done | output | 1 | Result strobe, one cycle after a request |
| range_err | output | 1 | Slot would overrun the vector |
| illegal | output | 1 | Instruction word not recognised |

## Verification
The done strobe always coincides with the result, and it can also coincide with one of the two fault flags. Directed tasks drive a legal encoding at an index just past the limit for each width, such as 15 for halfwords and 9 for doublewords. The bench then judges that done and range_err rise together, that vec_out equals the incoming vector, and that illegal stays low. It also drives a malformed word while vec_in differs from the held result. That case is judged by done and illegal rising together while vec_out keeps the earlier result.

// File: rtl/vins_pkg.sv
package vins_pkg;
    localparam int VEC_BYTES = 16;
    localparam int VEC_W     = VEC_BYTES * 8;
    localparam int SRC_W     = 64;
    localparam int IDX_W     = 64;
    localparam int INSTR_W   = 32;
    localparam int IDX_LSB   = $clog2(VEC_BYTES);
    localparam int POS_W     = IDX_LSB + 1;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } elem_sz_e;

    typedef struct packed {
        logic     legal;
        logic     right;
        elem_sz_e sz;
    } dec_t;

    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic             done;
        logic             rerr;
        logic             ill;
    } state_t;
endpackage

// File: rtl/vins_decode.sv
module vins_decode
    import vins_pkg::*;
#(
    parameter logic [5:0] PRIMARY = 6'b000100
) (
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic [5:0]  prim;
    logic [10:0] ext;
    logic        unused_fields;

    assign prim          = instr[31:26];
    assign ext           = instr[10:0];
    assign unused_fields = ^instr[25:11];

    always_comb begin
        dec.legal = (prim == PRIMARY) && (ext[10:9] == 2'b01) && (ext[5:0] == 6'b001111);
        dec.right = ext[8];
        dec.sz    = elem_sz_e'(ext[7:6]);
    end
endmodule

// File: rtl/vins_index.sv
module vins_index
    import vins_pkg::*;
(
    input  elem_sz_e         sz,
    input  logic             right,
    input  logic [IDX_W-1:0] idx_reg,
    output logic [POS_W-1:0] nbytes,
    output logic [POS_W-1:0] shift_lanes,
    output logic             in_range
);
    logic [POS_W-1:0] raw;
    logic [POS_W-1:0] limit;
    logic             unused_idx_hi;

    assign unused_idx_hi = ^idx_reg[IDX_W-1:IDX_LSB];

    always_comb begin
        raw      = POS_W'(idx_reg[IDX_LSB-1:0]);
        nbytes   = POS_W'(1) << sz;
        limit    = POS_W'(VEC_BYTES) - nbytes;
        in_range = (raw <= limit);
        // lanes counted from the least significant byte: left form sits
        // limit-raw lanes up, right form sits raw lanes up
        shift_lanes = right ? raw : (limit - raw);
    end
endmodule

// File: rtl/vins_merge.sv
module vins_merge
    import vins_pkg::*;
(
    input  logic [VEC_W-1:0]     old_vec,
    input  logic [SRC_W-1:0]     src,
    input  logic [POS_W-1:0]     nbytes,
    input  logic [POS_W-1:0]     shift_lanes,
    output logic [VEC_BYTES-1:0] lane_en,
    output logic [VEC_W-1:0]     new_vec
);
    localparam int SRC_BYTES = SRC_W / 8;

    logic [SRC_W-1:0]     src_m;
    logic [VEC_BYTES-1:0] base_en;
    logic [VEC_W-1:0]     aligned;

    always_comb begin
        for (int b = 0; b < SRC_BYTES; b++) begin
            src_m[b*8 +: 8] = (b < int'(nbytes)) ? src[b*8 +: 8] : 8'h00;
        end
        base_en = ({{(VEC_BYTES-1){1'b0}}, 1'b1} << nbytes) - 1'b1;
        lane_en = base_en << shift_lanes;
        aligned = {{(VEC_W-SRC_W){1'b0}}, src_m} << {shift_lanes, 3'b000};
    end

    for (genvar j = 0; j < VEC_BYTES; j++) begin : g_lane
        assign new_vec[j*8 +: 8] = lane_en[j] ? aligned[j*8 +: 8] : old_vec[j*8 +: 8];
    end
endmodule

// File: rtl/vec_insert_unit.sv
module vec_insert_unit
    import vins_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [SRC_W-1:0]   src_val,
    input  logic [IDX_W-1:0]   idx_reg,
    input  logic [VEC_W-1:0]   vec_in,
    output logic [VEC_W-1:0]   vec_out,
    output logic               done,
    output logic               range_err,
    output logic               illegal
);
    dec_t                 dec;
    logic [POS_W-1:0]     nbytes;
    logic [POS_W-1:0]     shift_lanes;
    logic                 in_range;
    logic [VEC_BYTES-1:0] lane_en;
    logic [VEC_W-1:0]     merged;
    state_t               st_d, st_q;

    vins_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    vins_index u_idx (
        .sz          (dec.sz),
        .right       (dec.right),
        .idx_reg     (idx_reg),
        .nbytes      (nbytes),
        .shift_lanes (shift_lanes),
        .in_range    (in_range)
    );

    vins_merge u_mrg (
        .old_vec     (vec_in),
        .src         (src_val),
        .nbytes      (nbytes),
        .shift_lanes (shift_lanes),
        .lane_en     (lane_en),
        .new_vec     (merged)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = req_valid;
        st_d.rerr = 1'b0;
        st_d.ill  = 1'b0;
        if (req_valid) begin
            if (!dec.legal) begin
                st_d.ill = 1'b1;
            end else if (!in_range) begin
                st_d.rerr = 1'b1;
                st_d.vec  = vec_in;
            end else begin
                st_d.vec  = merged;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign vec_out   = st_q.vec;
    assign done      = st_q.done;
    assign range_err = st_q.rerr;
    assign illegal   = st_q.ill;

    // R9
    done_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> done);
    // R9
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!done && !range_err && !illegal && $stable(vec_out)));
    // R8
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(range_err && illegal));
    // R7
    range_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && dec.legal && !in_range) |=> (range_err && vec_out == $past(vec_in)));
    // R6
    lane_count_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && dec.legal && in_range) |-> ($countones(lane_en) == int'(nbytes)));
endmodule

// File: tb/tb_vec_insert_unit.sv
module tb_vec_insert_unit;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic [63:0]  src_val = '0;
    logic [63:0]  idx_reg = '0;
    logic [127:0] vec_in = '0;
    logic [127:0] vec_out;
    logic         done, range_err, illegal;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_insert_unit dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .instr(instr),
        .src_val(src_val), .idx_reg(idx_reg), .vec_in(vec_in),
        .vec_out(vec_out), .done(done), .range_err(range_err), .illegal(illegal)
    );

    function automatic logic [31:0] mk_instr(input bit right, input logic [1:0] szc);
        return {6'b000100, 5'd3, 5'd7, 5'd9, 2'b01, right, szc, 6'b001111};
    endfunction

    function automatic logic [127:0] ref_ins(input logic [127:0] old, input logic [63:0] src,
                                              input int n, input int pos);
        logic [127:0] r = old;
        for (int k = 0; k < n; k++) r[127-8*(pos+k) -: 8] = src[8*(n-1-k) +: 8];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] ins, input logic [63:0] src,
                         input logic [63:0] idx, input logic [127:0] v);
        @(negedge clk);
        instr = ins; src_val = src; idx_reg = idx; vec_in = v; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // legal insert with bench-side expectation (R2 R4 R5 R6 R7 R9)
    task automatic run_ins(input string req, input bit right, input logic [1:0] szc,
                           input logic [63:0] idx, input logic [63:0] src,
                           input logic [127:0] v);
        int n = 1 << szc;
        int raw = int'(idx[3:0]);
        bit ok_rng = (raw <= 16 - n);
        int pos = right ? (16 - n - raw) : raw;
        logic [127:0] exp = ok_rng ? ref_ins(v, src, n, pos) : v;
        issue(mk_instr(right, szc), src, idx, v);
        chk(vec_out == exp, req, vec_out, exp);
        chk(done == 1'b1 && illegal == 1'b0, {req, " R9 done"}, {126'b0, done, illegal}, 128'b10);
        chk(range_err == !ok_rng, {req, " R7 flag"}, range_err, !ok_rng);
    endtask

    task automatic t_reset;
        chk(vec_out == 0 && !done && !range_err && !illegal, "R10 reset",
            {vec_out[124:0], done, range_err, illegal}, 0);
    endtask

    task automatic t_left;
        logic [127:0] v = 128'h00112233_44556677_8899AABB_CCDDEEFF;
        run_ins("R4 byte idx0", 0, 2'd0, 0, 64'h1234_5678_9ABC_DEA5, v);
        run_ins("R4 byte idx15", 0, 2'd0, 15, 64'h5A, v);
        run_ins("R2 half idx14", 0, 2'd1, 14, 64'hFFFF_FFFF_FFFF_BEEF, v);
        run_ins("R6 word idx12", 0, 2'd2, 12, 64'hAAAA_AAAA_CAFE_F00D, v);
        run_ins("R6 dword idx8", 0, 2'd3, 8, 64'h0102_0304_0506_0708, v);
        run_ins("R4 word idx5", 0, 2'd2, 5, 64'h1111_2222_3333_4444, v);
    endtask

    task automatic t_right;
        logic [127:0] v = {16{8'hC3}};
        run_ins("R5 byte r0", 1, 2'd0, 0, 64'h77, v);
        run_ins("R5 half r3", 1, 2'd1, 3, 64'hABCD, v);
        run_ins("R5 word r12", 1, 2'd2, 12, 64'hDEAD_BEEF, v);
        run_ins("R5 dword r0", 1, 2'd3, 0, 64'hFEDC_BA98_7654_3210, v);
        run_ins("R5 dword r8", 1, 2'd3, 8, 64'h0011_2233_4455_6677, v);
    endtask

    task automatic t_range;
        logic [127:0] v = 128'h0F0E0D0C_0B0A0908_07060504_03020100;
        run_ins("R7 half l15", 0, 2'd1, 15, 64'h9999, v);
        run_ins("R7 dword l9", 0, 2'd3, 9, 64'h1, v);
        run_ins("R7 word r13", 1, 2'd2, 13, 64'h2, v);
        run_ins("R7 dword r15", 1, 2'd3, 15, 64'h3, v);
    endtask

    task automatic t_idx_hi;
        logic [127:0] v = '0;
        run_ins("R3 hi bits", 0, 2'd1, 64'hFFFF_FFFF_FFFF_FFF4, 64'h4321, v);
        run_ins("R3 hi bits right", 1, 2'd0, 64'h8000_0000_0000_0010, 64'hE1, v);
    endtask

    task automatic t_illegal;
        logic [127:0] held;
        logic [31:0] bad;
        run_ins("R1 setup", 0, 2'd2, 4, 64'h1357_9BDF, '1);
        held = vec_out;
        bad = mk_instr(0, 2'd2); bad[31:26] = 6'b000101;
        issue(bad, 64'h5, 0, 128'h1);
        chk(vec_out == held, "R8 hold primary", vec_out, held);
        chk(illegal && done && !range_err, "R8 flag primary", {illegal, done, range_err}, 3'b110);
        bad = mk_instr(1, 2'd3); bad[5:0] = 6'b001110;
        issue(bad, 64'h5, 0, 128'h2);
        chk(vec_out == held, "R1 ext mismatch hold", vec_out, held);
        chk(illegal == 1'b1, "R1 ext mismatch flag", illegal, 1);
        bad = mk_instr(0, 2'd0); bad[10:9] = 2'b11;
        issue(bad, 64'h5, 20, 128'h3);
        chk(illegal && !range_err && vec_out == held, "R8 bad bits10:9", vec_out, held);
    endtask

    task automatic t_idle;
        logic [127:0] held = vec_out;
        vec_in = '1; src_val = '1;
        repeat (3) @(negedge clk);
        chk(!done && !range_err && !illegal, "R9 idle flags", {done, range_err, illegal}, 0);
        chk(vec_out == held, "R9 idle hold", vec_out, held);
    endtask

    task automatic t_reset_mid;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(vec_out == 0 && !done, "R10 mid reset", vec_out, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_left();
        t_right();
        t_range();
        t_idx_hi();
        t_illegal();
        t_idle();
        t_reset_mid();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule